// File: doc/BRIEF.md
# CRC-Protected Configuration Record Store

This block keeps a four-byte configuration record in a byte-wide nonvolatile memory. It reaches that memory through a plain read/write port. Reads return data one cycle after the read strobe. A write is accepted only in a cycle where the memory signals that it is ready. The record carries a size byte, a speed-setting byte and a 16-bit checksum. The checksum is the reflected CCITT CRC with polynomial 0x8408, processed LSB first, with initial value 0x0000.

Coming out of reset, the block reads the four bytes and runs the CRC over all of them. It adopts the stored speed only if the CRC residue is zero and the size byte is 4. In any other case it falls back to a default record whose speed code is the fastest setting, and it writes that record back to the memory at once.

A store request takes a new speed value. The block rebuilds the record with the size byte forced to 4, computes a new checksum, and writes the four bytes in order, one byte per ready cycle. A request that arrives while the block is busy is held and carried out as soon as the current operation ends.

Top module: `cfg_record_store`

## Requirements
- R1: While reset is held and just after it, busy is 1, valid is 0 and speed equals the DEFAULT_SPEED parameter. The first memory access after reset is a read of address 0, and the load then reads addresses 0 to 3.
- R2: A loaded record with byte 0 equal to 4 whose CRC over all four bytes gives a zero residue is adopted. Speed becomes byte 1 and no write is issued.
- R3: A loaded record with a nonzero residue is replaced by the default record (size 4, speed DEFAULT_SPEED, matching checksum), which is written to addresses 0 to 3. Speed shows DEFAULT_SPEED.
- R4: A loaded record whose size byte is not 4 is replaced by the default record and written back, even when its checksum is consistent.
- R5: A write is issued only in a cycle where mem_wr_ready is 1. Each record goes out at ascending addresses 0, 1, 2, 3. When mem_wr_ready stays high, the four writes take four consecutive cycles.
- R6: A written record has these fields: byte 0 = 4, byte 1 = speed, byte 2 = CRC low byte, byte 3 = CRC high byte. The CRC is the reflected CCITT CRC (0x8408, init 0x0000) over bytes 0 and 1.
- R7: A store request while idle sets the speed output to the requested value and writes the new record.
- R8: Store requests made while busy are held. When the current operation ends, only the most recent one is written, once.
- R9: busy falls only when an operation has finished. valid rises at the end of the first load or write-back and then stays high. No memory access happens while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; a load starts when it is released |
| store_req | input | 1 | One-cycle request to store a new speed setting |
| store_speed | input | 8 | Speed value that goes with store_req |
| speed | output | 8 | Current speed setting |
| busy | output | 1 | High while a load or a store is in progress |
| valid | output | 1 | High once the speed output comes from a checked or written record |
| mem_addr | output | AW | Byte address for the memory |
| mem_rd_en | output | 1 | Read strobe; data is returned on the following cycle |
| mem_rd_data | input | 8 | Read data from the memory |
| mem_wr_en | output | 1 | Write strobe, issued only while mem_wr_ready is high |
| mem_wr_data | output | 8 | Write data |
| mem_wr_ready | input | 1 | Memory is able to accept a write this cycle |

## Verification
The bench builds the block with AW = 4 and DEFAULT_SPEED = 0x5A. The nonzero default can be told apart from an erased or zero speed byte, and the small address space keeps the stub memory tiny. The stub's write-ready latency is set per run: 0 keeps ready high so that back-to-back writes occur, and 2 or 3 stretch the record over many waiting cycles. A request issued during the startup load and a chain of requests during a store both exercise the held-request path.

// File: rtl/cfgrec_pkg.sv
package cfgrec_pkg;

    localparam int          REC_BYTES = 4;
    localparam logic [7:0]  REC_SIZE  = 8'd4;
    localparam logic [15:0] CRC_POLY  = 16'h8408;

    typedef enum logic [2:0] {
        ST_RD    = 3'd0,
        ST_CAP   = 3'd1,
        ST_CHECK = 3'd2,
        ST_WR    = 3'd3,
        ST_IDLE  = 3'd4
    } st_e;

    // byte i of the record sits at bits [8i+7:8i]
    typedef struct packed {
        logic [15:0] crc;
        logic [7:0]  speed;
        logic [7:0]  size;
    } rec_t;

    function automatic logic [15:0] crc_step(input logic [15:0] c_in, input logic [7:0] b);
        logic [15:0] c;
        c = c_in ^ {8'h00, b};
        for (int k = 0; k < 8; k++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/cfgrec_crc_chain.sv
module cfgrec_crc_chain
    import cfgrec_pkg::*;
#(
    parameter int NB = 2
) (
    input  logic [15:0]       seed,
    input  logic [8*NB-1:0]   bytes_in,
    output logic [15:0]       crc_out
);
    logic [15:0] stage [0:NB];

    assign stage[0] = seed;

    for (genvar g = 0; g < NB; g++) begin : g_step
        assign stage[g+1] = crc_step(stage[g], bytes_in[8*g +: 8]);
    end

    assign crc_out = stage[NB];
endmodule

// File: rtl/cfgrec_req_hold.sv
module cfgrec_req_hold #(
    parameter int VW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic [VW-1:0] req_val,
    input  logic          take,
    output logic          want,
    output logic [VW-1:0] want_val
);
    logic          pend_q;
    logic [VW-1:0] pend_val_q;

    assign want     = req | pend_q;
    assign want_val = req ? req_val : pend_val_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= 1'b0;
            pend_val_q <= '0;
        end else if (take) begin
            pend_q <= 1'b0;
        end else if (req) begin
            pend_q     <= 1'b1;
            pend_val_q <= req_val;
        end
    end
endmodule

// File: rtl/cfg_record_store.sv
module cfg_record_store
    import cfgrec_pkg::*;
#(
    parameter int         AW            = 8,
    parameter logic [7:0] DEFAULT_SPEED = 8'h00
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          store_req,
    input  logic [7:0]    store_speed,
    output logic [7:0]    speed,
    output logic          busy,
    output logic          valid,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd_en,
    input  logic [7:0]    mem_rd_data,
    output logic          mem_wr_en,
    output logic [7:0]    mem_wr_data,
    input  logic          mem_wr_ready
);
    localparam int IW = $clog2(REC_BYTES);
    localparam logic [IW-1:0] LAST_IDX = IW'(REC_BYTES - 1);

    st_e           st;
    logic [IW-1:0] idx;
    rec_t          rec;
    logic [15:0]   crc_acc;
    logic [7:0]    speed_q;
    logic          valid_q;

    logic [15:0]   crc_next;
    logic [15:0]   store_crc;
    logic [15:0]   dflt_crc;
    logic          want;
    logic [7:0]    want_val;
    logic          rec_ok;
    logic          done_now;
    logic          start_store;

    // running residue while the record is read in
    cfgrec_crc_chain #(.NB(1)) u_crc_load (
        .seed     (crc_acc),
        .bytes_in (mem_rd_data),
        .crc_out  (crc_next)
    );

    // checksum of a freshly requested record
    cfgrec_crc_chain #(.NB(2)) u_crc_store (
        .seed     (16'h0000),
        .bytes_in ({want_val, REC_SIZE}),
        .crc_out  (store_crc)
    );

    // checksum of the fallback record
    cfgrec_crc_chain #(.NB(2)) u_crc_dflt (
        .seed     (16'h0000),
        .bytes_in ({DEFAULT_SPEED, REC_SIZE}),
        .crc_out  (dflt_crc)
    );

    cfgrec_req_hold #(.VW(8)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .req      (store_req),
        .req_val  (store_speed),
        .take     (start_store),
        .want     (want),
        .want_val (want_val)
    );

    assign rec_ok      = (crc_acc == 16'h0000) && (rec.size == REC_SIZE);
    assign done_now    = ((st == ST_CHECK) && rec_ok) ||
                         ((st == ST_WR) && mem_wr_ready && (idx == LAST_IDX));
    assign start_store = want && ((st == ST_IDLE) || done_now);

    assign mem_rd_en   = (st == ST_RD);
    assign mem_wr_en   = (st == ST_WR) && mem_wr_ready;
    assign mem_addr    = AW'(idx);
    assign mem_wr_data = rec[{idx, 3'b000} +: 8];

    assign busy  = (st != ST_IDLE);
    assign valid = valid_q;
    assign speed = speed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_RD;
            idx     <= '0;
            rec     <= '0;
            crc_acc <= 16'h0000;
            speed_q <= DEFAULT_SPEED;
            valid_q <= 1'b0;
        end else begin
            unique case (st)
                ST_RD: st <= ST_CAP;
                ST_CAP: begin
                    rec[{idx, 3'b000} +: 8] <= mem_rd_data;
                    crc_acc <= crc_next;
                    idx     <= idx + 1'b1;
                    st      <= (idx == LAST_IDX) ? ST_CHECK : ST_RD;
                end
                ST_CHECK: begin
                    if (rec_ok) begin
                        speed_q <= rec.speed;
                        valid_q <= 1'b1;
                        st      <= ST_IDLE;
                    end else begin
                        rec     <= '{crc: dflt_crc, speed: DEFAULT_SPEED, size: REC_SIZE};
                        speed_q <= DEFAULT_SPEED;
                        idx     <= '0;
                        st      <= ST_WR;
                    end
                end
                ST_WR: begin
                    if (mem_wr_ready) begin
                        idx <= idx + 1'b1;
                        if (idx == LAST_IDX) begin
                            valid_q <= 1'b1;
                            st      <= ST_IDLE;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase

            if (start_store) begin
                rec     <= '{crc: store_crc, speed: want_val, size: REC_SIZE};
                speed_q <= want_val;
                idx     <= '0;
                st      <= ST_WR;
            end
        end
    end
endmodule

// File: rtl/cfg_record_store_chk.sv
module cfg_record_store_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          valid,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd_en,
    input logic          mem_wr_en,
    input logic [7:0]    mem_wr_data,
    input logic          mem_wr_ready
);
    logic [AW-1:0] last_wr_addr;

    always_ff @(posedge clk) begin
        if (rst) last_wr_addr <= '0;
        else if (mem_wr_en) last_wr_addr <= mem_addr;
    end

    assert_wr_needs_ready_R5: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> mem_wr_ready);

    assert_wr_ascending_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && (mem_addr != '0)) |-> (mem_addr == last_wr_addr + 1'b1));

    assert_size_byte_first_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && (mem_addr == '0)) |-> (mem_wr_data == 8'd4));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_wr_en && !mem_rd_en));

    assert_valid_at_end_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> valid);

    assert_valid_sticks_R9: assert property (@(posedge clk) disable iff (rst)
        valid |=> valid);

    assert_one_access_R1: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_en && mem_wr_en));
endmodule

bind cfg_record_store cfg_record_store_chk #(.AW(AW)) u_chk (.*);

// File: tb/cfg_record_store_bench.sv
module cfg_record_store_bench;
    localparam int         AW   = 4;
    localparam logic [7:0] DFLT = 8'h5A;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst;
    logic          store_req;
    logic [7:0]    store_speed;
    logic [7:0]    speed;
    logic          busy, valid;
    logic [AW-1:0] mem_addr;
    logic          mem_rd_en, mem_wr_en, mem_wr_ready;
    logic [7:0]    mem_rd_data, mem_wr_data;

    cfg_record_store #(.AW(AW), .DEFAULT_SPEED(DFLT)) u_cfg_record_store (
        .clk(clk), .rst(rst), .store_req(store_req), .store_speed(store_speed),
        .speed(speed), .busy(busy), .valid(valid), .mem_addr(mem_addr),
        .mem_rd_en(mem_rd_en), .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en),
        .mem_wr_data(mem_wr_data), .mem_wr_ready(mem_wr_ready)
    );

    // memory stub with adjustable write-ready latency
    logic [7:0]    mem [0:(1<<AW)-1];
    int            lat;
    int            wcnt;
    logic          pl_we;
    logic [AW-1:0] pl_addr;
    logic [7:0]    pl_data;

    always @(posedge clk) begin
        if (pl_we) mem[pl_addr] <= pl_data;
        if (mem_rd_en) mem_rd_data <= mem[mem_addr];
        if (rst) begin
            mem_wr_ready <= 1'b1;
            wcnt         <= 0;
        end else if (mem_wr_en) begin
            mem[mem_addr] <= mem_wr_data;
            wcnt          <= lat;
            mem_wr_ready  <= (lat == 0);
        end else if (wcnt > 0) begin
            wcnt <= wcnt - 1;
            if (wcnt == 1) mem_wr_ready <= 1'b1;
        end
    end

    int         vectors = 0;
    int         miscmp  = 0;
    int         cyc     = 0;
    int         wr_seen = 0;
    int         first_wr = 0;
    int         last_wr  = 0;
    int         wr_idx   = 0;
    logic       mon_on   = 1'b0;
    logic [7:0] exp_speed = DFLT;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscmp++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] c;
        logic [7:0]  bytes [2];
        c = 16'h0000;
        bytes[0] = a;
        bytes[1] = b;
        for (int j = 0; j < 2; j++) begin
            c = c ^ {8'h00, bytes[j]};
            for (int k = 0; k < 8; k++) begin
                if (c[0]) c = (c >> 1) ^ 16'h8408;
                else      c = c >> 1;
            end
        end
        return c;
    endfunction

    // per-clock comparison against the expected behaviour
    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            wr_idx = 0;
        end else begin
            if (mem_wr_en) begin
                chk(mem_wr_ready, "R5 write only when ready", 0, 1);
                chk(int'(mem_addr) == wr_idx, "R5 ascending address", int'(mem_addr), wr_idx);
                if (wr_seen == 0) first_wr = cyc;
                last_wr = cyc;
                wr_seen++;
                wr_idx = (wr_idx + 1) % 4;
            end
            if (mon_on && !busy) begin
                chk(speed == exp_speed, "R7 idle speed", int'(speed), int'(exp_speed));
                chk(valid, "R9 valid when idle", int'(valid), 1);
                chk(!mem_rd_en && !mem_wr_en, "R9 idle quiet", int'(mem_rd_en), 0);
                chk(wr_idx == 0, "R5 whole records", wr_idx, 0);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_idle(input string tag);
        int n;
        n = 0;
        do begin
            tick();
            n++;
        end while (busy && n < 3000);
        chk(!busy, tag, int'(busy), 0);
    endtask

    task automatic boot(input logic [7:0] b0, input logic [7:0] b1,
                        input logic [7:0] b2, input logic [7:0] b3, input int l);
        logic [7:0] img [4];
        img[0] = b0; img[1] = b1; img[2] = b2; img[3] = b3;
        mon_on = 1'b0;
        rst = 1'b1;
        store_req = 1'b0;
        lat = l;
        for (int i = 0; i < 4; i++) begin
            tick();
            pl_we = 1'b1;
            pl_addr = AW'(i);
            pl_data = img[i];
        end
        tick();
        pl_we = 1'b0;
        tick();
        chk(busy == 1'b1, "R1 busy in reset", int'(busy), 1);
        chk(valid == 1'b0, "R1 valid in reset", int'(valid), 0);
        chk(speed == DFLT, "R1 default speed in reset", int'(speed), int'(DFLT));
        wr_seen = 0;
        rst = 1'b0;
        chk(mem_rd_en && (mem_addr == '0), "R1 first read at address 0", int'(mem_addr), 0);
    endtask

    task automatic store(input logic [7:0] v);
        tick();
        store_req = 1'b1;
        store_speed = v;
        exp_speed = v;
        tick();
        store_req = 1'b0;
    endtask

    task automatic chk_record(input logic [7:0] spd, input string tag);
        logic [15:0] c;
        c = ref_crc(8'd4, spd);
        chk(mem[0] == 8'd4, {tag, " R6 size byte"}, int'(mem[0]), 4);
        chk(mem[1] == spd, {tag, " R6 speed byte"}, int'(mem[1]), int'(spd));
        chk(mem[2] == c[7:0], {tag, " R6 crc low"}, int'(mem[2]), int'(c[7:0]));
        chk(mem[3] == c[15:8], {tag, " R6 crc high"}, int'(mem[3]), int'(c[15:8]));
    endtask

    initial begin
        logic [15:0] c;
        rst = 1'b1; store_req = 1'b0; store_speed = 8'h00;
        pl_we = 1'b0; pl_addr = '0; pl_data = 8'h00; lat = 0;

        // good record is adopted without a write
        c = ref_crc(8'd4, 8'h02);
        boot(8'd4, 8'h02, c[7:0], c[15:8], 2);
        wait_idle("R9 load finishes");
        chk(speed == 8'h02, "R2 adopted speed", int'(speed), 2);
        chk(wr_seen == 0, "R2 no write-back", wr_seen, 0);
        chk(valid, "R9 valid after load", int'(valid), 1);
        exp_speed = 8'h02; mon_on = 1'b1;
        repeat (5) tick();

        // corrupted checksum
        c = ref_crc(8'd4, 8'h02);
        boot(8'd4, 8'h02, c[7:0] ^ 8'h01, c[15:8], 2);
        wait_idle("R9 repair finishes");
        chk(speed == DFLT, "R3 default speed", int'(speed), int'(DFLT));
        chk(wr_seen == 4, "R3 four writes", wr_seen, 4);
        chk_record(DFLT, "R3");
        exp_speed = DFLT; mon_on = 1'b1;
        repeat (5) tick();

        // consistent checksum but wrong size
        c = ref_crc(8'd5, 8'h02);
        boot(8'd5, 8'h02, c[7:0], c[15:8], 1);
        wait_idle("R9 repair finishes");
        chk(speed == DFLT, "R4 default speed", int'(speed), int'(DFLT));
        chk(wr_seen == 4, "R4 four writes", wr_seen, 4);
        chk_record(DFLT, "R4");
        exp_speed = DFLT; mon_on = 1'b1;

        // idle store with slow memory
        lat = 3;
        wr_seen = 0;
        store(8'h37);
        chk(busy, "R7 store starts", int'(busy), 1);
        wait_idle("R9 store finishes");
        chk(wr_seen == 4, "R7 four writes", wr_seen, 4);
        chk(speed == 8'h37, "R7 new speed", int'(speed), 'h37);
        chk_record(8'h37, "R7");

        // requests while busy: only the latest one follows
        lat = 2;
        wr_seen = 0;
        store(8'h11);
        store(8'h22);
        store(8'h33);
        wait_idle("R9 chained stores finish");
        chk(wr_seen == 8, "R8 two records written", wr_seen, 8);
        chk(speed == 8'h33, "R8 latest speed", int'(speed), 'h33);
        chk_record(8'h33, "R8");

        // request during startup load, always-ready memory
        c = ref_crc(8'd4, 8'h44);
        boot(8'd4, 8'h44, c[7:0], c[15:8], 0);
        store_req = 1'b1;
        store_speed = 8'h55;
        exp_speed = 8'h55;
        tick();
        store_req = 1'b0;
        wait_idle("R9 load plus store finishes");
        chk(wr_seen == 4, "R8 held request written", wr_seen, 4);
        chk(speed == 8'h55, "R8 held speed", int'(speed), 'h55);
        chk(last_wr - first_wr == 3, "R5 back-to-back writes", last_wr - first_wr, 3);
        chk_record(8'h55, "R8");
        mon_on = 1'b1;
        repeat (5) tick();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        miscmp++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end
endmodule